// File: doc/BRIEF.md
# Programmable Sum-of-Products Logic Array

This block is the programmable logic core of a small configurable-logic macro. It combines twelve dedicated inputs and ten feedback lines from the output cells into product terms. Each term is selected by a row of configuration fuses. The block then sums groups of those terms into ten outputs, one for each downstream output cell. The output cells themselves (registers, polarity and tristate control) are a separate block that consumes these sums.

Each product term is the AND of every literal whose fuse is connected. There are 22 input lines, and each line gives two literals, true and complement. A term with no connected fuse reads HIGH. A term that connects both polarities of any one line reads LOW. The number of terms that each OR gate collects differs from output to output. Beyond the OR terms, the block also provides the following special terms:

- one output-enable term for each output;
- one global asynchronous-reset term;
- one global synchronous-preset term.

Fuse rows are written one term at a time through a word-wide configuration port. This is done while the array is not in use. The array outputs themselves are purely combinational from the inputs and the stored fuses.

Top module: `pla_sop_array`

## Requirements
- R1: A synchronous active-low reset sets every fuse to connected. From the first clock edge after reset, every term and therefore every output (or_sum, oe_term, ar_term, sp_term) reads 0 whatever the inputs.
- R2: A term whose fuse row is all 0 (all open) reads 1 for every input pattern.
- R3: A term with both the true column 2j and the complement column 2j+1 of any line j connected reads 0 for every input pattern, even when all its other fuses are open.
- R4: Line j is in_ded[j] for j in 0..11 and fb[j-12] for j in 12..21. Fuse column 2j set to 1 makes a term require line j high. Column 2j+1 set to 1 makes it require line j low.
- R5: A term with several connected columns is the logical AND of all the selected literals.
- R6: or_sum[o] is the OR of its own terms. The per-output term counts, in output order, are 8,10,12,14,16,16,14,12,10,8. Sum-term addresses run contiguously from 0 in output order, so output o owns addresses base(o) to base(o)+count(o)-1.
- R7: Address 120+o holds the output-enable term of output o (oe_term[o]). Address 130 holds ar_term and address 131 holds sp_term.
- R8: A fuse row changes only at a clock edge with cfg_we high and cfg_addr below 132. Writes to addresses 132..255, and any address or data presented with cfg_we low, change no output.
- R9: Outputs follow changes of in_ded and fb combinationally, with no clock edge in between.
- R10: A write replaces only the addressed fuse row. Every other term keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Synchronous active-low reset, connects all fuses |
| cfg_we | input | 1 | Fuse row write strobe |
| cfg_addr | input | 8 | Term address of the row being written |
| cfg_data | input | 44 | New fuse row, bit 2j true and bit 2j+1 complement of line j |
| in_ded | input | 12 | Dedicated inputs, lines 0..11 |
| fb | input | 10 | Output-cell feedback, lines 12..21 |
| or_sum | output | 10 | OR sum for each output cell |
| oe_term | output | 10 | Output-enable product term for each output cell |
| ar_term | output | 1 | Global asynchronous-reset product term |
| sp_term | output | 1 | Global synchronous-preset product term |

## Verification
The array is tried with several kinds of fuse row:

- **All-open and conflicting rows.** These are driven with alternating and walking input patterns. They separate the forced-HIGH and forced-LOW term semantics from real literal evaluation.
- **Single-literal rows.** These use true and complement columns on both a dedicated input and a feedback line, and show that the column-to-line mapping and the polarity are right.
- **Multi-literal rows.** These are swept over every combination of their inputs, which distinguishes AND from OR behaviour.
- **The first and last term of every output.** Opening each in turn pins down the per-output term counts and the address boundaries between neighbouring outputs.
- **Out-of-range and unstrobed writes.** These show that stray configuration traffic is ignored.

// File: rtl/pla_pkg.sv
// Package pla_pkg
// Shared sizing constants and the term-count shape of the AND-OR array.
// Assumes the term count grows by a fixed step toward the middle outputs
// and shrinks symmetrically toward the last output.
package pla_pkg;

    localparam int PLA_N_IN      = 12;
    localparam int PLA_N_FB      = 10;
    localparam int PLA_N_OUT     = 10;
    localparam int PLA_MIN_TERMS = 8;
    localparam int PLA_STEP      = 2;

    // Number of OR terms owned by output o.
    function automatic int terms_of(input int o, input int n_out,
                                    input int min_t, input int step);
        int d;
        d = (o < (n_out - 1 - o)) ? o : (n_out - 1 - o);
        return min_t + step * d;
    endfunction

    // First term address owned by output o (o == n_out gives the total).
    function automatic int base_of(input int o, input int n_out,
                                   input int min_t, input int step);
        int acc;
        acc = 0;
        for (int k = 0; k < o; k++) begin
            acc += terms_of(k, n_out, min_t, step);
        end
        return acc;
    endfunction

endpackage

// File: rtl/pla_fuse_store.sv
// Module pla_fuse_store
// Holds one fuse row per product term and rewrites a row on a strobed write.
// Assumes writes happen only while the array outputs are not in use;
// addresses at or above N_TERMS are dropped.
module pla_fuse_store #(
    parameter int N_TERMS = 132,
    parameter int N_COL   = 44,
    parameter int ADDR_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [N_COL-1:0]  wr_data,
    output logic [N_COL-1:0]  fuse_q [N_TERMS]
);

    logic addr_ok;

    // Accept only addresses that name an existing term.
    always_comb addr_ok = (int'(wr_addr) < N_TERMS);

    // Reset connects every fuse; a valid write replaces one row.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int t = 0; t < N_TERMS; t++) begin
                fuse_q[t] <= '1;
            end
        end else if (wr_en && addr_ok) begin
            fuse_q[wr_addr] <= wr_data;
        end
    end

endmodule

// File: rtl/pla_and_term.sv
// Module pla_and_term
// One product term: the AND of every literal whose fuse is connected.
// Column 2j selects line j true, column 2j+1 selects line j complemented.
// An all-open row reads 1; both polarities of one line read 0.
module pla_and_term #(
    parameter int N_LINES = 22,
    localparam int N_COL  = 2 * N_LINES
) (
    input  logic [N_LINES-1:0] lines,
    input  logic [N_COL-1:0]   fuse_row,
    output logic               term
);

    // Each connected literal that is false pulls the term low.
    always_comb begin
        term = 1'b1;
        for (int j = 0; j < N_LINES; j++) begin
            if (fuse_row[2*j] && !lines[j]) begin
                term = 1'b0;
            end
            if (fuse_row[2*j+1] && lines[j]) begin
                term = 1'b0;
            end
        end
    end

endmodule

// File: rtl/pla_or_sum.sv
// Module pla_or_sum
// Fixed OR gate collecting COUNT product terms for one output.
// Assumes COUNT is at least 1.
module pla_or_sum #(
    parameter int COUNT = 8
) (
    input  logic [COUNT-1:0] terms,
    output logic             sum
);

    // Any active term drives the sum high.
    always_comb sum = |terms;

endmodule

// File: rtl/pla_sop_array.sv
// Module pla_sop_array
// Configurable AND-OR plane: forms product terms over dedicated inputs and
// feedback lines, sums per-output groups of unequal size, and provides one
// output-enable term per output plus two global terms.
// Term addresses: sum terms first in output order, then output enables,
// then asynchronous reset, then synchronous preset.
// Assumes fuse rows are written only while outputs are not being used.
module pla_sop_array
    import pla_pkg::*;
#(
    parameter int N_IN      = PLA_N_IN,
    parameter int N_FB      = PLA_N_FB,
    parameter int N_OUT     = PLA_N_OUT,
    parameter int MIN_TERMS = PLA_MIN_TERMS,
    parameter int STEP      = PLA_STEP,
    localparam int N_LINES  = N_IN + N_FB,
    localparam int N_COL    = 2 * N_LINES,
    localparam int N_SUM    = base_of(N_OUT, N_OUT, MIN_TERMS, STEP),
    localparam int N_TERMS  = N_SUM + N_OUT + 2,
    localparam int ADDR_W   = $clog2(N_TERMS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [N_COL-1:0]  cfg_data,
    input  logic [N_IN-1:0]   in_ded,
    input  logic [N_FB-1:0]   fb,
    output logic [N_OUT-1:0]  or_sum,
    output logic [N_OUT-1:0]  oe_term,
    output logic              ar_term,
    output logic              sp_term
);

    localparam int AR_IDX = N_SUM + N_OUT;
    localparam int SP_IDX = N_SUM + N_OUT + 1;

    logic [N_LINES-1:0] line_vec;
    logic [N_COL-1:0]   fuse_q [N_TERMS];
    logic [N_TERMS-1:0] term_vec;

    // Lines 0..N_IN-1 are dedicated inputs, the rest are feedbacks.
    always_comb line_vec = {fb, in_ded};

    pla_fuse_store #(
        .N_TERMS (N_TERMS),
        .N_COL   (N_COL),
        .ADDR_W  (ADDR_W)
    ) u_fuses (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_addr (cfg_addr),
        .wr_data (cfg_data),
        .fuse_q  (fuse_q)
    );

    for (genvar t = 0; t < N_TERMS; t++) begin : g_term
        pla_and_term #(
            .N_LINES (N_LINES)
        ) u_term (
            .lines    (line_vec),
            .fuse_row (fuse_q[t]),
            .term     (term_vec[t])
        );
    end

    for (genvar o = 0; o < N_OUT; o++) begin : g_sum
        localparam int BASE = base_of(o, N_OUT, MIN_TERMS, STEP);
        localparam int CNT  = terms_of(o, N_OUT, MIN_TERMS, STEP);
        pla_or_sum #(
            .COUNT (CNT)
        ) u_sum (
            .terms (term_vec[BASE +: CNT]),
            .sum   (or_sum[o])
        );
    end

    // Special terms bypass the OR plane.
    always_comb begin
        oe_term = term_vec[N_SUM +: N_OUT];
        ar_term = term_vec[AR_IDX];
        sp_term = term_vec[SP_IDX];
    end

endmodule

// File: rtl/pla_sop_checker.sv
// Module pla_sop_checker
// Temporal properties of the AND-OR array, bound to pla_sop_array.
// Assumes fuse rows are stable apart from strobed in-range writes.
module pla_sop_checker
    import pla_pkg::*;
#(
    parameter int N_IN      = PLA_N_IN,
    parameter int N_FB      = PLA_N_FB,
    parameter int N_OUT     = PLA_N_OUT,
    parameter int MIN_TERMS = PLA_MIN_TERMS,
    parameter int STEP      = PLA_STEP,
    localparam int N_COL    = 2 * (N_IN + N_FB),
    localparam int N_SUM    = base_of(N_OUT, N_OUT, MIN_TERMS, STEP),
    localparam int N_TERMS  = N_SUM + N_OUT + 2,
    localparam int ADDR_W   = $clog2(N_TERMS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic [ADDR_W-1:0] cfg_addr,
    input logic [N_COL-1:0]  cfg_data,
    input logic [N_IN-1:0]   in_ded,
    input logic [N_FB-1:0]   fb,
    input logic [N_OUT-1:0]  or_sum,
    input logic [N_OUT-1:0]  oe_term,
    input logic              ar_term,
    input logic              sp_term,
    input logic [N_TERMS-1:0] term_vec
);

    localparam int AR_ADDR = N_SUM + N_OUT;

    // R1: the edge after reset leaves every output low.
    p_reset_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (or_sum == '0 && oe_term == '0 && !ar_term && !sp_term));

    // R8: without an in-range write and with steady inputs, outputs hold.
    p_no_write_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (!$past(cfg_we) || int'($past(cfg_addr)) >= N_TERMS)
         && $stable(in_ded) && $stable(fb))
        |-> ($stable(or_sum) && $stable(oe_term) && $stable(ar_term) && $stable(sp_term)));

    // R2: an all-open row written to the reset term reads high.
    p_open_row_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cfg_we) && int'($past(cfg_addr)) == AR_ADDR
         && $past(cfg_data) == '0) |-> ar_term);

    // R3: a fully connected row written to the reset term reads low.
    p_conflict_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cfg_we) && int'($past(cfg_addr)) == AR_ADDR
         && $past(cfg_data) == '1) |-> !ar_term);

    // R6: an output can be high only if one of its own terms is high.
    for (genvar o = 0; o < N_OUT; o++) begin : g_own
        localparam int BASE = base_of(o, N_OUT, MIN_TERMS, STEP);
        localparam int CNT  = terms_of(o, N_OUT, MIN_TERMS, STEP);
        p_sum_from_own_terms_r6: assert property (@(posedge clk) disable iff (!rst_n)
            or_sum[o] |-> (|term_vec[BASE +: CNT]));
    end

endmodule

bind pla_sop_array pla_sop_checker #(
    .N_IN      (N_IN),
    .N_FB      (N_FB),
    .N_OUT     (N_OUT),
    .MIN_TERMS (MIN_TERMS),
    .STEP      (STEP)
) i_pla_sop_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_addr (cfg_addr),
    .cfg_data (cfg_data),
    .in_ded   (in_ded),
    .fb       (fb),
    .or_sum   (or_sum),
    .oe_term  (oe_term),
    .ar_term  (ar_term),
    .sp_term  (sp_term),
    .term_vec (term_vec)
);

// File: tb/test_pla_sop_array.sv
// Directed bench for pla_sop_array: one task per scenario.
module test_pla_sop_array;

    localparam int CLK_PERIOD = 10;
    localparam int N_COL      = 44;
    localparam int N_TERMS    = 132;
    localparam int N_OUT      = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [43:0] cfg_data = '0;
    logic [11:0] in_ded = '0;
    logic [9:0]  fb = '0;
    logic [9:0]  or_sum;
    logic [9:0]  oe_term;
    logic        ar_term;
    logic        sp_term;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    pla_sop_array i_pla_sop_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_addr (cfg_addr),
        .cfg_data (cfg_data),
        .in_ded   (in_ded),
        .fb       (fb),
        .or_sum   (or_sum),
        .oe_term  (oe_term),
        .ar_term  (ar_term),
        .sp_term  (sp_term)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Per-output term counts taken from the requirements.
    function automatic int cnt_of(input int o);
        int c [10] = '{8, 10, 12, 14, 16, 16, 14, 12, 10, 8};
        return c[o];
    endfunction

    function automatic int base(input int o);
        int acc = 0;
        for (int k = 0; k < o; k++) acc += cnt_of(k);
        return acc;
    endfunction

    function automatic logic [43:0] lit_t(input int j);
        return 44'd1 << (2 * j);
    endfunction

    function automatic logic [43:0] lit_c(input int j);
        return 44'd1 << (2 * j + 1);
    endfunction

    function automatic logic [21:0] all_out();
        return {sp_term, ar_term, oe_term, or_sum};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cfg_we = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
    endtask

    task automatic write_term(input int addr, input logic [43:0] d);
        @(negedge clk);
        cfg_we   = 1'b1;
        cfg_addr = addr[7:0];
        cfg_data = d;
        @(negedge clk);
        cfg_we = 1'b0;
        #1;
    endtask

    task automatic set_in(input logic [11:0] d, input logic [9:0] f);
        in_ded = d;
        fb     = f;
        #1;
    endtask

    task automatic t_reset_state();
        do_reset();
        set_in(12'hFFF, 10'h3FF);
        check("R1 all high inputs", 32'(all_out()), 32'h0);
        set_in(12'hA5A, 10'h155);
        check("R1 mixed inputs", 32'(all_out()), 32'h0);
    endtask

    task automatic t_open_high();
        do_reset();
        write_term(base(3), '0);
        set_in(12'h000, 10'h000);
        check("R2 open term zeros", 32'(or_sum), 32'h8);
        set_in(12'hFFF, 10'h3FF);
        check("R2 open term ones", 32'(or_sum), 32'h8);
        set_in(12'h5A5, 10'h2AA);
        check("R2 open term mixed", 32'(or_sum), 32'h8);
    endtask

    task automatic t_conflict_low();
        do_reset();
        write_term(base(3), lit_t(5) | lit_c(5));
        for (int p = 0; p < 4; p++) begin
            set_in(p[0] ? 12'hFFF : 12'h000, p[1] ? 10'h3FF : 10'h000);
            check("R3 dedicated line conflict", 32'(or_sum), 32'h0);
        end
        write_term(base(3), lit_t(15) | lit_c(15));
        set_in(12'hFFF, 10'h008);
        check("R3 feedback line conflict", 32'(or_sum), 32'h0);
    endtask

    task automatic t_literal();
        do_reset();
        write_term(base(3), lit_t(2));
        set_in(12'h004, 10'h000);
        check("R4 true literal high", 32'(or_sum[3]), 32'h1);
        set_in(12'hFFB, 10'h3FF);
        check("R4 true literal low", 32'(or_sum[3]), 32'h0);
        write_term(base(3), lit_c(14));
        set_in(12'h000, 10'h004);
        check("R4 complement feedback high input", 32'(or_sum[3]), 32'h0);
        set_in(12'hFFF, 10'h3FB);
        check("R4 complement feedback low input", 32'(or_sum[3]), 32'h1);
    endtask

    task automatic t_and();
        do_reset();
        write_term(base(3), lit_t(0) | lit_t(1) | lit_c(12));
        for (int p = 0; p < 8; p++) begin
            logic e;
            set_in({10'h0, p[1], p[0]}, {9'h0, p[2]});
            e = p[0] & p[1] & ~p[2];
            check("R5 three-literal AND", 32'(or_sum[3]), 32'(e));
        end
    endtask

    task automatic t_counts();
        do_reset();
        set_in(12'h000, 10'h000);
        for (int o = 0; o < N_OUT; o++) begin
            write_term(base(o), '0);
            check("R6 first term of output", 32'(or_sum), 32'(1 << o));
            write_term(base(o), '1);
            write_term(base(o) + cnt_of(o) - 1, '0);
            check("R6 last term of output", 32'(or_sum), 32'(1 << o));
            write_term(base(o) + cnt_of(o) - 1, '1);
        end
        write_term(base(0), lit_t(0));
        write_term(base(0) + 7, lit_t(1));
        for (int p = 0; p < 4; p++) begin
            set_in({10'h0, p[1], p[0]}, 10'h0);
            check("R6 OR of two terms", 32'(or_sum[0]), 32'(p[0] | p[1]));
        end
    endtask

    task automatic t_special();
        do_reset();
        for (int o = 0; o < N_OUT; o++) begin
            write_term(120 + o, '0);
            check("R7 output enable term", 32'(all_out()), 32'(1 << (10 + o)));
            write_term(120 + o, '1);
        end
        write_term(130, '0);
        check("R7 async reset term", 32'(all_out()), 32'(1 << 20));
        write_term(130, '1);
        write_term(131, '0);
        check("R7 sync preset term", 32'(all_out()), 32'(1 << 21));
    endtask

    task automatic t_ignore();
        do_reset();
        set_in(12'h3C3, 10'h0F0);
        for (int a = N_TERMS; a < 256; a += 31) begin
            write_term(a, '0);
            check("R8 out-of-range write", 32'(all_out()), 32'h0);
        end
        write_term(255, '0);
        check("R8 top address write", 32'(all_out()), 32'h0);
        @(negedge clk);
        cfg_addr = 8'(base(4));
        cfg_data = '0;
        repeat (3) @(negedge clk);
        #1;
        check("R8 unstrobed write", 32'(all_out()), 32'h0);
    endtask

    task automatic t_comb();
        do_reset();
        write_term(base(0), lit_t(0));
        @(negedge clk);
        set_in(12'h001, 10'h0);
        check("R9 rise without clock", 32'(or_sum[0]), 32'h1);
        set_in(12'h000, 10'h0);
        check("R9 fall without clock", 32'(or_sum[0]), 32'h0);
    endtask

    task automatic t_isolation();
        do_reset();
        set_in(12'h000, 10'h000);
        write_term(base(2), '0);
        write_term(base(2) + 1, lit_t(3) | lit_c(3));
        check("R10 neighbour write keeps term", 32'(or_sum), 32'h4);
        write_term(base(3), '0);
        check("R10 second output added", 32'(or_sum), 32'hC);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_open_high();
        t_conflict_low();
        t_literal();
        t_and();
        t_counts();
        t_special();
        t_ignore();
        t_comb();
        t_isolation();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule